// File: doc/BRIEF.md
# Eight-Character Text Line Buffer

This block holds one line of eight text characters in a small register buffer. A bus master reaches it through a request port with a valid/ready handshake, and can read or write 1, 2, 4 or 8 bytes starting at any of the eight byte offsets. Each access wraps inside the buffer. Byte k of an access goes to buffer index (offset + k) mod 8, so an access that starts near the top continues from index 0. Data lanes are little-endian: the lowest-addressed byte sits in the least significant lane.

Read data comes back one cycle after the read is accepted. Lanes beyond the access size read as zero. Every accepted write raises a one-cycle refresh pulse. The whole line is always presented on a parallel output, so a downstream display driver can redraw it. When a display attaches for the first time, the line is filled with blanks. That fill happens only once per reset.

Top module: `textline_buf`

## Requirements
- R1: After reset, `line_out` is all zero, `refresh` and `rsp_valid` are low, and `req_ready` is high.
- R2: An accepted write with `req_size` 0, 1, 2 or 3 stores 1, 2, 4 or 8 bytes. Byte k of the access is `req_wdata[8k+7:8k]` and lands at buffer index (`req_addr` + k) mod 8. Buffer index i is shown at `line_out[8i+7:8i]`.
- R3: An access whose bytes run past index 7 continues at index 0.
- R4: A write leaves every buffer index outside its byte range unchanged.
- R5: An accepted read raises `rsp_valid` for one cycle on the next cycle. Lane k of `rsp_rdata` then holds buffer index (`req_addr` + k) mod 8.
- R6: Lanes of `rsp_rdata` at or above the access size read as zero.
- R7: In the cycle after each accepted write, `refresh` is high and `line_out` already shows the updated line. `refresh` is low when the previous cycle accepted neither a write nor an init fill.
- R8: A read changes neither the line nor `refresh`.
- R9: The first `attach` after reset fills all eight indices with 0x20. In that cycle `req_ready` is low, and `refresh` pulses the cycle after.
- R10: Any later `attach` has no effect: `req_ready` stays high, and the line and `refresh` are untouched.
- R11: A request offered while `req_ready` is low is not accepted and has no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Starting byte offset |
| req_size | input | 2 | Access size code: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| req_wdata | input | 64 | Write data, byte k in lane k |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data, upper lanes zero |
| attach | input | 1 | Display attach event |
| refresh | output | 1 | Line redraw pulse |
| line_out | output | 64 | Whole line, index i in bits [8i+7:8i] |

## Verification
The assertions assume that a request is either a read or a write, that its size code is one of the four legal values, and that `attach` is sampled on the same edge as requests. The stimulus drives every input on the falling edge. It holds `req_valid` for exactly one cycle per transaction. The only request that overlaps an attach is the one meant to show the stall of R11. Offsets and sizes are swept so that wrapping accesses and full-width accesses both occur.

// File: rtl/textline_pkg.sv
package textline_pkg;

  typedef enum logic [1:0] {
    ACC_B1 = 2'd0,
    ACC_B2 = 2'd1,
    ACC_B4 = 2'd2,
    ACC_B8 = 2'd3
  } acc_size_e;

  // number of bytes covered by a size code
  function automatic int unsigned acc_bytes(input acc_size_e sz);
    return 32'd1 << sz;
  endfunction

  // which lane of an access starting at base lands on buffer index idx
  function automatic int unsigned lane_of(input int unsigned idx,
                                          input int unsigned base,
                                          input int unsigned n);
    return (idx + n - base) % n;
  endfunction

  // which buffer index lane k of an access starting at base touches
  function automatic int unsigned index_of(input int unsigned k,
                                           input int unsigned base,
                                           input int unsigned n);
    return (base + k) % n;
  endfunction

endpackage

// File: rtl/tl_write_steer.sv
module tl_write_steer
  import textline_pkg::*;
#(
  parameter  int NBYTES = 8,
  localparam int IDX_W  = $clog2(NBYTES),
  localparam int DATA_W = 8 * NBYTES
) (
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  base,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] wdata,
  output logic [NBYTES-1:0] byte_we,
  output logic [DATA_W-1:0] byte_wd
);

  for (genvar i = 0; i < NBYTES; i++) begin : g_idx
    logic [IDX_W-1:0] lane;
    assign lane            = IDX_W'(lane_of(i, 32'(base), NBYTES));
    assign byte_we[i]      = wr_en && (32'(lane) < acc_bytes(size));
    assign byte_wd[8*i +: 8] = wdata[8*lane +: 8];
  end

endmodule

// File: rtl/tl_read_gather.sv
module tl_read_gather
  import textline_pkg::*;
#(
  parameter  int NBYTES = 8,
  localparam int IDX_W  = $clog2(NBYTES),
  localparam int DATA_W = 8 * NBYTES
) (
  input  logic [IDX_W-1:0]  base,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] line,
  output logic [DATA_W-1:0] rdata
);

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    logic [IDX_W-1:0] idx;
    assign idx = IDX_W'(index_of(k, 32'(base), NBYTES));
    assign rdata[8*k +: 8] = (k < acc_bytes(size)) ? line[8*idx +: 8] : 8'h00;
  end

endmodule

// File: rtl/textline_buf.sv
module textline_buf
  import textline_pkg::*;
#(
  parameter  int         NBYTES = 8,
  parameter  logic [7:0] BLANK  = 8'h20,
  localparam int         IDX_W  = $clog2(NBYTES),
  localparam int         DATA_W = 8 * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              attach,
  output logic              refresh,
  output logic [DATA_W-1:0] line_out
);

  // ---------------- state ----------------
  logic [DATA_W-1:0] line_q, line_d;
  logic              init_done_q;
  logic              refresh_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  acc_size_e         rd_size_q;

  // ---------------- named events ----------------
  logic              init_fire;
  logic              acc;
  logic              wr_acc;
  logic              rd_acc;
  acc_size_e         size_e;
  logic [NBYTES-1:0] byte_we;
  logic [DATA_W-1:0] byte_wd;
  logic [DATA_W-1:0] rd_gather;

  assign size_e    = acc_size_e'(req_size);
  assign init_fire = attach && !init_done_q;
  assign req_ready = !init_fire;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;

  tl_write_steer #(.NBYTES(NBYTES)) u_wsteer (
    .wr_en   (wr_acc),
    .base    (req_addr),
    .size    (size_e),
    .wdata   (req_wdata),
    .byte_we (byte_we),
    .byte_wd (byte_wd)
  );

  tl_read_gather #(.NBYTES(NBYTES)) u_rgather (
    .base  (req_addr),
    .size  (size_e),
    .line  (line_q),
    .rdata (rd_gather)
  );

  always_comb begin
    line_d = line_q;
    for (int i = 0; i < NBYTES; i++) begin
      if (init_fire)       line_d[8*i +: 8] = BLANK;
      else if (byte_we[i]) line_d[8*i +: 8] = byte_wd[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q      <= '0;
      init_done_q <= 1'b0;
      refresh_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rd_size_q   <= ACC_B1;
    end else begin
      line_q      <= line_d;
      if (init_fire) init_done_q <= 1'b1;
      refresh_q   <= wr_acc || init_fire;
      rsp_valid_q <= rd_acc;
      if (rd_acc) begin
        rsp_rdata_q <= rd_gather;
        rd_size_q   <= size_e;
      end
    end
  end

  assign line_out  = line_q;
  assign refresh   = refresh_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  // ---------------- assertions ----------------
  logic [DATA_W-1:0] rsp_keep;
  always_comb
    for (int k = 0; k < NBYTES; k++)
      rsp_keep[8*k +: 8] = (k < acc_bytes(rd_size_q)) ? 8'hFF : 8'h00;

  p_write_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |-> ($countones(byte_we) == acc_bytes(size_e)));

  p_rsp_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~rsp_keep) == '0));

  p_refresh_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> refresh);

  p_refresh_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_acc && !init_fire) |=> !refresh);

  p_read_keeps_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_acc && !init_fire) |=> $stable(line_out));

  p_init_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_fire |=> (!init_fire && req_ready));

  p_stall_no_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready) |=> !rsp_valid);

endmodule

// File: tb/textline_buf_bench.sv
`timescale 1ns/1ps
module textline_buf_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        attach = 1'b0;
  logic        refresh;
  logic [63:0] line_out;

  always #2.5 clk = ~clk;

  textline_buf u_textline_buf (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .attach(attach), .refresh(refresh), .line_out(line_out)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0]  model [8];
  logic [63:0] exp_q [$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_line();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = model[i];
    return v;
  endfunction

  // reference read: walk the bytes the access covers, wrapping by hand
  function automatic logic [63:0] model_read(input int a, input int sz);
    logic [63:0] v = '0;
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 8;
    int p = a;
    for (int k = 0; k < n; k++) begin
      v[8*k +: 8] = model[p];
      p = (p == 7) ? 0 : p + 1;
    end
    return v;
  endfunction

  task automatic model_write(input int a, input int sz, input logic [63:0] d);
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 8;
    int p = a;
    for (int k = 0; k < n; k++) begin
      model[p] = d[8*k +: 8];
      p = (p == 7) ? 0 : p + 1;
    end
  endtask

  // driver: write, then check line and refresh in the following cycle
  task automatic do_write(input string tag, input int a, input int sz, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'(a); req_size = 2'(sz); req_wdata = d;
    model_write(a, sz, d);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk({tag, " line"}, line_out, model_line());
    chk("R7 refresh after write", {63'd0, refresh}, 64'd1);
  endtask

  // driver: read, push expectation for the monitor
  task automatic do_read(input int a, input int sz);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 3'(a); req_size = 2'(sz);
    exp_q.push_back(model_read(a, sz));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R5 response arrived next cycle", 64'(exp_q.size()), 64'd0);
    chk("R8 read leaves line", line_out, model_line());
    chk("R8 no refresh on read", {63'd0, refresh}, 64'd0);
  endtask

  // monitor: pops expectations as responses appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk("R5 unexpected response", 64'd1, 64'd0);
      else chk("R5/R6 read data", rsp_rdata, exp_q.pop_front());
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 line reset", line_out, 64'd0);
    chk("R1 refresh reset", {63'd0, refresh}, 64'd0);
    chk("R1 rsp_valid reset", {63'd0, rsp_valid}, 64'd0);
    chk("R1 ready reset", {63'd0, req_ready}, 64'd1);

    do_write("R2 byte", 3, 0, 64'h41);
    do_write("R3 half wrap", 7, 1, 64'h4342);
    do_write("R3 word wrap", 6, 2, 64'h47464544);
    do_write("R2 full wrap", 5, 3, 64'h5756555453525150);
    do_write("R4 partial keeps rest", 2, 1, 64'hFFFF_FFFF_FFFF_6261);
    @(negedge clk);
    chk("R7 refresh drops when idle", {63'd0, refresh}, 64'd0);

    for (int sz = 0; sz < 4; sz++)
      for (int a = 0; a < 8; a += 3) do_read(a, sz);
    do_read(7, 2);
    do_read(7, 3);

    // first attach with a write offered in the same cycle
    @(negedge clk);
    attach = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd0; req_size = 2'd3;
    req_wdata = 64'h0102030405060708;
    #1;
    chk("R9 ready low during fill", {63'd0, req_ready}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    attach = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = 8'h20;
    chk("R9/R11 line blank, stalled write dropped", line_out, model_line());
    chk("R9 refresh after fill", {63'd0, refresh}, 64'd1);

    do_write("R2 after fill", 1, 1, 64'h6968);

    // later attach ignored
    @(negedge clk);
    attach = 1'b1;
    #1;
    chk("R10 ready stays high", {63'd0, req_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    attach = 1'b0;
    chk("R10 line untouched", line_out, model_line());
    chk("R10 no refresh", {63'd0, refresh}, 64'd0);

    do_read(0, 3);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule